// File: doc/BRIEF.md
# A/D Channel Scan Sequencer with Settling Guard

This block steps an external analog-to-digital converter through a programmable band of input channels. A host programs it through a byte-wide register port: one register holds the top and bottom channels of the band, one holds the gain code, the sequencing mode and a page selection, one reports status, and a key register switches an enhanced mode on or off. Each trigger pulse either converts the channel under an internal pointer and steps that pointer, or sweeps the whole band in one burst. The converter itself sits outside and is reached through a start pulse and a done pulse.

Any change to the band or to the gain/mode register disturbs the analog front end, so the block raises a settling flag for a fixed number of clock cycles after such a write. A new write restarts the interval. While the flag is up, or while a conversion or sweep is in progress, triggers are refused and a sticky error bit records the refusal.

Top module: `adscan_ctrl`

## Requirements
- R1: After reset, conv_start_o, sts_o, settle_o, chan_o, gain_o and page_o are all 0, and the status register reads 0x00.
- R2: A write to address 0 stores the band top channel from bits 7:4 and the bottom channel from bits 3:0, reads back unchanged at address 0, and moves the pointer (chan_o) to the new bottom channel from the next cycle.
- R3: With address 1 bit 2 clear (single mode), each accepted trigger gives one conv_start_o pulse with chan_o equal to the pointer; on conv_done_i the pointer steps up by one, or returns to the bottom channel when it equalled the top channel.
- R4: With address 1 bit 2 set (sweep mode), one accepted trigger gives conv_start_o pulses on every channel from bottom to top in rising order, each after the done of the previous one; afterwards the pointer rests on the bottom channel.
- R5: sts_o rises in the cycle after an accepted trigger and stays high until the cycle after the done pulse of the last conversion that trigger called for; conv_start_o only pulses while sts_o is high.
- R6: A write to address 0 or 1 raises settle_o from the next cycle for exactly SETTLE_CYC cycles.
- R7: A write to address 0 or 1 while settle_o is high restarts the interval, so settle_o falls SETTLE_CYC cycles after the last such write.
- R8: Address 1 bits 1:0 drive gain_o for all channels; address 1 reads back as bits 2:0 as written with bits 7:3 read as 0, so the page bits never appear.
- R9: Address 1 bits 7:6 reach page_o only while enhanced mode is on; writing 0xA5 to address 3 turns it on, 0xA6 turns it off, any other value leaves it unchanged; when off, page_o is 0.
- R10: A trigger arriving while settle_o or sts_o is high starts nothing and sets the error flag (status bit 5), which stays set until any write to address 2 clears it.
- R11: Address 2 reads status: bit 7 sts_o, bit 6 settle_o, bit 5 error flag, bit 4 zero, bits 3:0 the pointer; host_rdata shows the register selected by host_addr one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | 2 | Register address for reads and writes |
| host_wr | input | 1 | Write strobe, one cycle per write |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Registered read data for host_addr |
| trig_i | input | 1 | Conversion trigger, sampled every cycle |
| conv_start_o | output | 1 | One-cycle start pulse to the converter |
| conv_done_i | input | 1 | Converter done pulse |
| chan_o | output | 4 | Channel pointer driving the input multiplexer |
| gain_o | output | 2 | Gain code for all channels |
| page_o | output | 2 | Active register page, 0 unless enhanced mode |
| sts_o | output | 1 | Conversion or sweep in progress |
| settle_o | output | 1 | Front end settling, conversions blocked |

## Verification
A pointer that steps wrong shows on chan_o at the very next conv_start_o pulse, so comparing each start's channel with a bench model of the band catches it within one conversion; an end-of-band slip in sweep mode also changes the number of starts per trigger. A settling counter off by one or not restarted moves the falling edge of settle_o, which the bench times cycle-exactly after single and back-to-back writes. Enable gating of the page and the refused-trigger path are seen at once on page_o and on the status error bit read back after the stimulus.

// File: rtl/adscan_pkg.sv
package adscan_pkg;
  localparam int DW  = 8;
  localparam int CHW = 4;

  typedef enum logic [1:0] {
    A_RANGE = 2'd0,
    A_CFG   = 2'd1,
    A_STAT  = 2'd2,
    A_KEY   = 2'd3
  } addr_e;

  localparam logic [DW-1:0] KEY_ON  = 8'hA5;
  localparam logic [DW-1:0] KEY_OFF = 8'hA6;

  localparam int SCAN_BIT = 2;

  typedef enum logic {SQ_IDLE = 1'b0, SQ_CONV = 1'b1} sq_e;
endpackage

// File: rtl/adscan_regs.sv
module adscan_regs
  import adscan_pkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  logic [1:0]     addr,
  input  logic           wr,
  input  logic [DW-1:0]  wdata,
  input  logic           sts,
  input  logic           settle,
  input  logic           err,
  input  logic [CHW-1:0] ptr,
  output logic [CHW-1:0] lo_o,
  output logic [CHW-1:0] hi_o,
  output logic           scan_o,
  output logic [1:0]     gain_o,
  output logic [1:0]     page_o,
  output logic           range_wr_o,
  output logic           cfg_wr_o,
  output logic           stat_wr_o,
  output logic [DW-1:0]  rdata_o
);
  logic [1:0] page_q;
  logic       enh_q;

  assign range_wr_o = wr && (addr == A_RANGE);
  assign cfg_wr_o   = wr && (addr == A_CFG);
  assign stat_wr_o  = wr && (addr == A_STAT);
  assign page_o     = enh_q ? page_q : 2'b00;

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_o   <= '0;
      hi_o   <= '0;
      scan_o <= 1'b0;
      gain_o <= 2'b00;
      page_q <= 2'b00;
      enh_q  <= 1'b0;
    end else if (wr) begin
      unique case (addr)
        A_RANGE: begin
          hi_o <= wdata[7:4];
          lo_o <= wdata[3:0];
        end
        A_CFG: begin
          page_q <= wdata[7:6];
          scan_o <= wdata[SCAN_BIT];
          gain_o <= wdata[1:0];
        end
        A_KEY: begin
          if (wdata == KEY_ON)       enh_q <= 1'b1;
          else if (wdata == KEY_OFF) enh_q <= 1'b0;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_o <= '0;
    end else begin
      unique case (addr)
        A_RANGE: rdata_o <= {hi_o, lo_o};
        A_CFG:   rdata_o <= {5'b00000, scan_o, gain_o};
        A_STAT:  rdata_o <= {sts, settle, err, 1'b0, ptr};
        default: rdata_o <= '0;
      endcase
    end
  end

  AST_KEY_OFF_PAGE: assert property (@(posedge clk) disable iff (rst)
    (wr && addr == A_KEY && wdata == KEY_OFF) |=> (page_o == 2'b00)); // R9
  AST_CFG_READ_HIDES_PAGE: assert property (@(posedge clk) disable iff (rst)
    (addr == A_CFG) |=> (rdata_o[7:3] == 5'b00000)); // R8
  AST_GAIN_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (rst)
    (wr && addr == A_CFG) |=> (gain_o == $past(wdata[1:0]))); // R8
endmodule

// File: rtl/adscan_settle.sv
module adscan_settle #(
  parameter int CYC = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic kick,
  output logic busy_o
);
  localparam int CW = $clog2(CYC + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (kick)        cnt <= CW'(CYC);
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign busy_o = (cnt != '0);

  AST_SETTLE_RAISE: assert property (@(posedge clk) disable iff (rst)
    kick |=> busy_o); // R6
  AST_SETTLE_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(CYC)); // R7
endmodule

// File: rtl/adscan_seq.sv
module adscan_seq
  import adscan_pkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  logic           trig,
  input  logic           done,
  input  logic           scan,
  input  logic [CHW-1:0] lo,
  input  logic [CHW-1:0] hi,
  input  logic           range_wr,
  input  logic [CHW-1:0] new_lo,
  input  logic           settle,
  input  logic           err_clr,
  output logic           start_o,
  output logic [CHW-1:0] ptr_o,
  output logic           sts_o,
  output logic           err_o
);
  sq_e  state;
  logic accept;
  logic at_top;

  assign accept = trig && !settle && (state == SQ_IDLE);
  assign at_top = (ptr_o == hi);
  assign sts_o  = (state == SQ_CONV);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= SQ_IDLE;
      ptr_o   <= '0;
      start_o <= 1'b0;
      err_o   <= 1'b0;
    end else begin
      start_o <= 1'b0;
      if (trig && !accept) err_o <= 1'b1;
      else if (err_clr)    err_o <= 1'b0;

      unique case (state)
        SQ_IDLE: begin
          if (accept) begin
            state   <= SQ_CONV;
            start_o <= 1'b1;
            if (scan) ptr_o <= lo;
          end
        end
        SQ_CONV: begin
          if (done) begin
            if (scan && !at_top) begin
              ptr_o   <= ptr_o + 1'b1;
              start_o <= 1'b1;
            end else begin
              state <= SQ_IDLE;
              ptr_o <= at_top ? lo : ptr_o + 1'b1;
            end
          end
        end
        default: state <= SQ_IDLE;
      endcase

      if (range_wr) ptr_o <= new_lo;
    end
  end

  AST_ACCEPT_STARTS: assert property (@(posedge clk) disable iff (rst)
    (trig && !settle && !sts_o) |=> (start_o && sts_o)); // R3
  AST_SETTLE_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    (trig && settle && !sts_o) |=> !start_o); // R10
  AST_REFUSED_FLAGGED: assert property (@(posedge clk) disable iff (rst)
    (trig && (settle || sts_o)) |=> err_o); // R10
  AST_SINGLE_ENDS: assert property (@(posedge clk) disable iff (rst)
    (sts_o && done && !scan) |=> !sts_o); // R3
  AST_SWEEP_ENDS: assert property (@(posedge clk) disable iff (rst)
    (sts_o && done && scan && at_top) |=> !sts_o); // R4
  AST_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    start_o |-> sts_o); // R5
endmodule

// File: rtl/adscan_ctrl.sv
module adscan_ctrl
  import adscan_pkg::*;
#(
  parameter int SETTLE_CYC = 1000
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [1:0]     host_addr,
  input  logic           host_wr,
  input  logic [DW-1:0]  host_wdata,
  output logic [DW-1:0]  host_rdata,
  input  logic           trig_i,
  output logic           conv_start_o,
  input  logic           conv_done_i,
  output logic [CHW-1:0] chan_o,
  output logic [1:0]     gain_o,
  output logic [1:0]     page_o,
  output logic           sts_o,
  output logic           settle_o
);
  logic [CHW-1:0] lo, hi;
  logic           scan, range_wr, cfg_wr, stat_wr, err;

  adscan_regs u_regs (
    .clk        (clk),
    .rst        (rst),
    .addr       (host_addr),
    .wr         (host_wr),
    .wdata      (host_wdata),
    .sts        (sts_o),
    .settle     (settle_o),
    .err        (err),
    .ptr        (chan_o),
    .lo_o       (lo),
    .hi_o       (hi),
    .scan_o     (scan),
    .gain_o     (gain_o),
    .page_o     (page_o),
    .range_wr_o (range_wr),
    .cfg_wr_o   (cfg_wr),
    .stat_wr_o  (stat_wr),
    .rdata_o    (host_rdata)
  );

  adscan_settle #(.CYC(SETTLE_CYC)) u_settle (
    .clk    (clk),
    .rst    (rst),
    .kick   (range_wr || cfg_wr),
    .busy_o (settle_o)
  );

  adscan_seq u_seq (
    .clk      (clk),
    .rst      (rst),
    .trig     (trig_i),
    .done     (conv_done_i),
    .scan     (scan),
    .lo       (lo),
    .hi       (hi),
    .range_wr (range_wr),
    .new_lo   (host_wdata[CHW-1:0]),
    .settle   (settle_o),
    .err_clr  (stat_wr),
    .start_o  (conv_start_o),
    .ptr_o    (chan_o),
    .sts_o    (sts_o),
    .err_o    (err)
  );

  AST_RANGE_WRITE_PTR: assert property (@(posedge clk) disable iff (rst)
    (host_wr && host_addr == A_RANGE) |=> (chan_o == $past(host_wdata[3:0]))); // R2
  AST_WRITE_SETTLES: assert property (@(posedge clk) disable iff (rst)
    (host_wr && (host_addr == A_RANGE || host_addr == A_CFG)) |=> settle_o); // R6
endmodule

// File: tb/adscan_ctrl_bench.sv
module adscan_ctrl_bench;
  localparam int N = 40;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] host_addr = 2'd0;
  logic       host_wr = 1'b0;
  logic [7:0] host_wdata = 8'h00;
  logic [7:0] host_rdata;
  logic       trig_i = 1'b0;
  logic       conv_start_o;
  logic       conv_done_i = 1'b0;
  logic [3:0] chan_o;
  logic [1:0] gain_o, page_o;
  logic       sts_o, settle_o;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;
  int got_ch[64];
  int got_n = 0;

  always #5 clk = ~clk;

  adscan_ctrl #(.SETTLE_CYC(N)) u_adscan_ctrl (
    .clk(clk), .rst(rst), .host_addr(host_addr), .host_wr(host_wr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .trig_i(trig_i),
    .conv_start_o(conv_start_o), .conv_done_i(conv_done_i), .chan_o(chan_o),
    .gain_o(gain_o), .page_o(page_o), .sts_o(sts_o), .settle_o(settle_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic int nxt(input int p, input int lo, input int hi);
    return (p == hi) ? lo : ((p + 1) & 15);
  endfunction

  // converter model: records the channel at each start, answers after 0..3 cycles
  initial begin
    forever begin
      @(negedge clk);
      while (conv_start_o) begin
        if (got_n < 64) got_ch[got_n] = int'(chan_o);
        got_n++;
        repeat ($urandom_range(0, 3)) @(negedge clk);
        conv_done_i = 1'b1;
        @(negedge clk);
        conv_done_i = 1'b0;
      end
    end
  end

  task automatic hwrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    host_addr = a; host_wr = 1'b1; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic hread(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk);
    host_addr = a;
    @(negedge clk);
    v = host_rdata;
  endtask

  task automatic wait_settle();
    while (settle_o) @(negedge clk);
  endtask

  task automatic fire(input bit extra);
    @(negedge clk);
    trig_i = 1'b1;
    @(negedge clk);
    trig_i = extra;
    chk("R5 sts after accepted trigger", int'(sts_o), 1);
    if (extra) begin
      @(negedge clk);
      trig_i = 1'b0;
    end
    for (int t = 0; t < 2000 && sts_o; t++) @(negedge clk);
  endtask

  initial begin
    #(150000 * 10);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int k, ptr;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1 chan_o", int'(chan_o), 0);
    chk("R1 sts_o", int'(sts_o), 0);
    chk("R1 settle_o", int'(settle_o), 0);
    chk("R1 gain_o", int'(gain_o), 0);
    chk("R1 page_o", int'(page_o), 0);
    chk("R1 conv_start_o", int'(conv_start_o), 0);
    hread(2'd2, v);
    chk("R1 status read", int'(v), 0);

    // R2 / R6: band 0..2, exact settling length
    hwrite(2'd0, 8'h20);
    chk("R2 pointer to bottom", int'(chan_o), 0);
    repeat (N - 1) @(negedge clk);
    chk("R6 settle still high at N-1", int'(settle_o), 1);
    @(negedge clk);
    chk("R6 settle low at N", int'(settle_o), 0);
    hread(2'd0, v);
    chk("R2 range readback", int'(v), 8'h20);

    // R8 / R9: gain, hidden page, enhanced off
    hwrite(2'd1, 8'hC3);
    chk("R8 gain_o", int'(gain_o), 3);
    chk("R9 page gated off", int'(page_o), 0);
    hread(2'd1, v);
    chk("R8 cfg readback hides page", int'(v), 8'h03);
    wait_settle();

    // R3 single mode wrap
    got_n = 0;
    repeat (4) fire(1'b0);
    chk("R3 single count", got_n, 4);
    chk("R3 single ch0", got_ch[0], 0);
    chk("R3 single ch1", got_ch[1], 1);
    chk("R3 single ch2", got_ch[2], 2);
    chk("R3 single wrap", got_ch[3], 0);
    chk("R3 pointer after", int'(chan_o), 1);

    // R10 trigger during settling
    hwrite(2'd1, 8'h03);
    k = got_n;
    @(negedge clk); trig_i = 1'b1;
    @(negedge clk); trig_i = 1'b0;
    repeat (3) @(negedge clk);
    chk("R10 no start while settling", got_n, k);
    hread(2'd2, v);
    chk("R10 error flag set", int'(v[5]), 1);
    chk("R11 status settle bit", int'(v[6]), 1);
    hwrite(2'd2, 8'h00);
    hread(2'd2, v);
    chk("R10 error flag cleared", int'(v[5]), 0);
    wait_settle();
    hread(2'd2, v);
    chk("R11 status pointer and bits", int'(v), 8'h01);

    // R7 back-to-back writes restart interval
    hwrite(2'd0, 8'h20);
    repeat (5) @(negedge clk);
    hwrite(2'd1, 8'h03);
    k = 0;
    while (settle_o && k < 10 * N) begin k++; @(negedge clk); end
    chk("R7 settle length after last write", k, N);
    chk("R2 pointer reset by range write", int'(chan_o), 0);

    // R9 enhanced mode keys
    hwrite(2'd1, 8'h83);
    hwrite(2'd3, 8'h11);
    chk("R9 other key no effect", int'(page_o), 0);
    hwrite(2'd3, 8'hA5);
    chk("R9 page on", int'(page_o), 2);
    hwrite(2'd3, 8'h5A);
    chk("R9 other key keeps on", int'(page_o), 2);
    hread(2'd1, v);
    chk("R8 cfg readback no page", int'(v), 8'h03);
    hwrite(2'd3, 8'hA6);
    chk("R9 page off", int'(page_o), 0);
    wait_settle();

    // R4 sweep 2..5, with a refused trigger during the sweep
    hwrite(2'd0, 8'h52);
    hwrite(2'd1, 8'h04);
    wait_settle();
    got_n = 0;
    fire(1'b1);
    chk("R4 sweep count", got_n, 4);
    for (int i = 0; i < 4; i++) chk("R4 sweep order", got_ch[i], 2 + i);
    chk("R4 pointer rests on bottom", int'(chan_o), 2);
    hread(2'd2, v);
    chk("R10 busy trigger flagged", int'(v[5]), 1);
    hwrite(2'd2, 8'h00);

    // random bands and modes
    for (int it = 0; it < 24; it++) begin
      int lo, hi, sc, g, nt, idx;
      bit ok;
      lo = $urandom_range(0, 15);
      hi = $urandom_range(lo, 15);
      sc = $urandom_range(0, 1);
      g  = $urandom_range(0, 3);
      nt = $urandom_range(1, 3);
      if (sc == 1) nt = 1;
      hwrite(2'd0, 8'((hi << 4) | lo));
      hwrite(2'd1, 8'((sc << 2) | g));
      wait_settle();
      chk("R8 random gain", int'(gain_o), g);
      got_n = 0;
      for (int t = 0; t < nt; t++) fire(1'b0);
      ok = 1'b1;
      idx = 0;
      ptr = lo;
      if (sc == 1) begin
        ok = (got_n == hi - lo + 1);
        for (int c = lo; c <= hi && idx < 64; c++) begin
          if (got_ch[idx] != c) ok = 1'b0;
          idx++;
        end
        chk("R4 random sweep", int'(ok), 1);
      end else begin
        ok = (got_n == nt);
        for (int t = 0; t < nt; t++) begin
          if (got_ch[t] != ptr) ok = 1'b0;
          ptr = nxt(ptr, lo, hi);
        end
        chk("R3 random single", int'(ok), 1);
        chk("R3 random pointer", int'(chan_o), ptr);
      end
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule